// File: doc/BRIEF.md
# Spilled-Register Provenance Tag Store

This block keeps the trust tags of registers that software spills to memory, so that a later reload can restore them. Every spill presents a word address and a one-bit tag (1 = the value came from a less trusted context). The block records the address in a "seen" filter and, for tagged spills, also in a "tagged" filter. Both filters are 256-bit Bloom filters addressed by two hashes of the word address, so the storage stays fixed no matter how many addresses are spilled.

A reload presents an address and, one cycle later, receives a taint flag. The answer fails safe. If the address was never recorded (its provenance is unknown), or if it may have been recorded with tag 1, the flag is 1 and the core must not speculate on the reloaded value. A false positive only costs speculation, never security. A clear input empties both filters in one cycle, for example on a context switch. After a clear, every reload reports taint until new spills arrive.

Top module: `spill_taint_filter`

## Requirements
- R1: During and after synchronous reset (`rst` high), `taint_vld` is 0, `taint` is 1, and both filters are empty, so every later query of an address not spilled since reset returns taint 1.
- R2: An address is hashed on its word index w = addr[31:2] (30 bits); bits [1:0] are ignored. Hash A is the XOR of the 8-bit chunks w[7:0], w[15:8], w[23:16] and w[29:24] (zero-extended). Hash B applies the same fold to w rotated left by 11 places within 30 bits.
- R3: A spill (`spill_vld` = 1), whatever its tag, sets the seen-filter bits at hash A and hash B of its address.
- R4: A spill with `spill_tag` = 1 also sets the tagged-filter bits at both hashes. A spill with tag 0 clears no bit, so an address once tagged stays tainted. Every tagged-filter bit is also set in the seen filter.
- R5: A query returns taint 1 when either of its seen bits is clear, or when both of its tagged bits are set; otherwise it returns 0.
- R6: `taint_vld` equals `query_vld` one cycle later. `taint` takes a new value only one cycle after a query, and holds its value otherwise.
- R7: `clr` empties both filters in one cycle. A spill in the same cycle as `clr` is discarded.
- R8: A query in the same cycle as a spill or a clear sees the filter state from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties both filters in one cycle |
| spill_vld | input | 1 | A register spill is presented this cycle |
| spill_addr | input | 32 | Byte address of the spill |
| spill_tag | input | 1 | Trust tag of the spilled register (1 = untrusted) |
| query_vld | input | 1 | A reload query is presented this cycle |
| query_addr | input | 32 | Byte address of the reload |
| taint_vld | output | 1 | Result of the query issued one cycle earlier is valid |
| taint | output | 1 | 1 = treat the reloaded value as untrusted |

## Verification
A spill and a query can fall in the same cycle, and so can a clear and either of them. The bench issues a tagged spill together with a query to the same, previously unseen address. It expects taint 1 from the old state, and then taint 1 again from a second query. An untagged spill paired with a query of its own address must give 1 first and 0 afterwards. A clear is paired with a query of a clean address, which must still answer 0 from the pre-clear state. A clear is also paired with a spill, which must leave the address unknown (taint 1).

// File: rtl/stf_pkg.sv
package stf_pkg;

    localparam int STF_ADDR_W = 32;
    localparam int STF_OFS_W  = 2;
    localparam int STF_IDX_W  = 8;
    localparam int STF_ROT    = 11;

    // Filter roles; the index picks the instance in the generate loop.
    typedef enum int {
        FLT_SEEN = 0,
        FLT_TAG  = 1
    } flt_role_e;

    localparam int STF_NUM_FLT = 2;

    // Outcome of probing both filters with one address.
    typedef struct packed {
        logic hit_seen;
        logic hit_tag;
    } probe_t;

    // Fail-safe verdict: unknown provenance or possible tag means untrusted.
    function automatic logic stf_verdict(input probe_t p);
        return (!p.hit_seen) || p.hit_tag;
    endfunction

endpackage

// File: rtl/stf_hash.sv
module stf_hash #(
    parameter int ADDR_W = stf_pkg::STF_ADDR_W,
    parameter int OFS_W  = stf_pkg::STF_OFS_W,
    parameter int IDX_W  = stf_pkg::STF_IDX_W,
    parameter int ROT    = stf_pkg::STF_ROT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b
);
    localparam int WW   = ADDR_W - OFS_W;
    localparam int NCH  = (WW + IDX_W - 1) / IDX_W;
    localparam int PADW = NCH * IDX_W;

    logic [WW-1:0]   word;
    logic [WW-1:0]   word_rot;
    logic [PADW-1:0] pad_w;
    logic [PADW-1:0] pad_r;

    assign word     = addr[ADDR_W-1:OFS_W];
    assign word_rot = (word << ROT) | (word >> (WW - ROT));
    assign pad_w    = PADW'(word);
    assign pad_r    = PADW'(word_rot);

    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int c = 0; c < NCH; c++) begin
            idx_a = idx_a ^ pad_w[c*IDX_W +: IDX_W];
            idx_b = idx_b ^ pad_r[c*IDX_W +: IDX_W];
        end
    end

    initial begin
        assert (ROT > 0 && ROT < WW)
            else $error("rotate amount out of range");
    end

endmodule

// File: rtl/stf_filter.sv
module stf_filter #(
    parameter int IDX_W  = stf_pkg::STF_IDX_W,
    parameter int N_BITS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_a,
    input  logic [IDX_W-1:0]  set_b,
    input  logic [IDX_W-1:0]  rd_a,
    input  logic [IDX_W-1:0]  rd_b,
    output logic              rd_hit,
    output logic [N_BITS-1:0] bits_o
);
    logic [N_BITS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (set_en) begin
            bits_q[set_a] <= 1'b1;
            bits_q[set_b] <= 1'b1;
        end
    end

    // Read reflects the state before this cycle's update.
    assign rd_hit = bits_q[rd_a] && bits_q[rd_b];
    assign bits_o = bits_q;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits_q == '0)) else $error("filter not empty after clear"); // R7

    AST_NO_BIT_DROPS: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((bits_q & $past(bits_q)) == $past(bits_q))) else $error("bit lost without clear"); // R4

    AST_SET_MARKS: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr) |=> (bits_q[$past(set_a)] && bits_q[$past(set_b)])) else $error("set did not mark"); // R3

endmodule

// File: rtl/spill_taint_filter.sv
module spill_taint_filter #(
    parameter int ADDR_W = stf_pkg::STF_ADDR_W,
    parameter int OFS_W  = stf_pkg::STF_OFS_W,
    parameter int IDX_W  = stf_pkg::STF_IDX_W,
    parameter int ROT    = stf_pkg::STF_ROT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              spill_vld,
    input  logic [ADDR_W-1:0] spill_addr,
    input  logic              spill_tag,
    input  logic              query_vld,
    input  logic [ADDR_W-1:0] query_addr,
    output logic              taint_vld,
    output logic              taint
);
    import stf_pkg::*;

    localparam int N_BITS = 1 << IDX_W;

    logic [IDX_W-1:0] sp_a, sp_b, qy_a, qy_b;
    logic [STF_NUM_FLT-1:0] set_en;
    logic [STF_NUM_FLT-1:0] hit;
    logic [N_BITS-1:0] flt_bits [STF_NUM_FLT];
    probe_t probe;
    logic taint_q, vld_q;

    stf_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ROT(ROT)) i_hash_spill (
        .addr (spill_addr),
        .idx_a(sp_a),
        .idx_b(sp_b)
    );

    stf_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ROT(ROT)) i_hash_query (
        .addr (query_addr),
        .idx_a(qy_a),
        .idx_b(qy_b)
    );

    for (genvar g = 0; g < STF_NUM_FLT; g++) begin : g_flt
        if (g == int'(FLT_SEEN)) begin : g_seen
            assign set_en[g] = spill_vld;
        end else begin : g_tag
            assign set_en[g] = spill_vld && spill_tag;
        end

        stf_filter #(.IDX_W(IDX_W), .N_BITS(N_BITS)) i_filter (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .set_en(set_en[g]),
            .set_a (sp_a),
            .set_b (sp_b),
            .rd_a  (qy_a),
            .rd_b  (qy_b),
            .rd_hit(hit[g]),
            .bits_o(flt_bits[g])
        );
    end

    assign probe.hit_seen = hit[FLT_SEEN];
    assign probe.hit_tag  = hit[FLT_TAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            taint_q <= 1'b1;
        end else begin
            vld_q <= query_vld;
            if (query_vld) begin
                taint_q <= stf_verdict(probe);
            end
        end
    end

    assign taint_vld = vld_q;
    assign taint     = taint_q;

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
        query_vld |=> taint_vld) else $error("valid did not follow query"); // R6

    AST_TAINT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !query_vld |=> ($stable(taint) && !taint_vld)) else $error("taint moved without query"); // R6

    AST_UNSEEN_TAINTED: assert property (@(posedge clk) disable iff (rst)
        (query_vld && !probe.hit_seen) |=> taint) else $error("unknown address reported clean"); // R5

    AST_TAG_WITHIN_SEEN: assert property (@(posedge clk) disable iff (rst)
        (flt_bits[FLT_TAG] & ~flt_bits[FLT_SEEN]) == '0) else $error("tag bit outside seen set"); // R4

endmodule

// File: tb/test_spill_taint_filter.sv
module test_spill_taint_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        spill_vld = 1'b0;
    logic [31:0] spill_addr = '0;
    logic        spill_tag = 1'b0;
    logic        query_vld = 1'b0;
    logic [31:0] query_addr = '0;
    logic        taint_vld;
    logic        taint;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spill_taint_filter i_spill_taint_filter (
        .clk(clk), .rst(rst), .clr(clr),
        .spill_vld(spill_vld), .spill_addr(spill_addr), .spill_tag(spill_tag),
        .query_vld(query_vld), .query_addr(query_addr),
        .taint_vld(taint_vld), .taint(taint)
    );

    // op 0 = spill (tag used), op 1 = query (exp used)
    typedef struct packed {
        logic        op;
        logic [31:0] addr;
        logic        tag;
        logic        exp;
    } vec_t;

    // Word index k = addr/4; for k < 256 hash A = k, hash B = ((k<<3)&255)^(k>>5)
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0004, 1'b0, 1'b1},  // R1 unseen after reset
        '{1'b0, 32'h0000_0004, 1'b0, 1'b0},  // spill k=1 tag 0
        '{1'b1, 32'h0000_0004, 1'b0, 1'b0},  // R5 seen, clean
        '{1'b1, 32'h0000_0007, 1'b0, 1'b0},  // R2 byte offset ignored
        '{1'b0, 32'h0000_0008, 1'b1, 1'b0},  // spill k=2 tag 1
        '{1'b1, 32'h0000_0008, 1'b0, 1'b1},  // R4 tagged
        '{1'b0, 32'h0000_0008, 1'b0, 1'b0},  // spill k=2 tag 0
        '{1'b1, 32'h0000_0008, 1'b0, 1'b1},  // R4 no deletion
        '{1'b0, 32'h0000_000C, 1'b0, 1'b0},  // spill k=3 tag 0
        '{1'b1, 32'h0000_000C, 1'b0, 1'b0},  // R3 seen clean
        '{1'b1, 32'h0000_0014, 1'b0, 1'b1},  // R5 unseen k=5
        '{1'b0, 32'h0000_0018, 1'b1, 1'b0},  // spill k=6 tag 1
        '{1'b0, 32'h0000_001C, 1'b0, 1'b0},  // spill k=7 tag 0
        '{1'b1, 32'h0000_001C, 1'b0, 1'b0},  // R5 k=7 clean
        '{1'b1, 32'h0000_0018, 1'b0, 1'b1},  // R4 k=6 tagged
        '{1'b1, 32'hDEAD_BEE1, 1'b0, 1'b1}   // R5 far address unseen
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; outputs are valid at the next one.
    task automatic cyc(input logic sv, input logic [31:0] sa, input logic st,
                       input logic qv, input logic [31:0] qa, input logic cl);
        spill_vld = sv; spill_addr = sa; spill_tag = st;
        query_vld = qv; query_addr = qa; clr = cl;
        @(negedge clk);
        spill_vld = 1'b0; query_vld = 1'b0; clr = 1'b0;
    endtask

    task automatic query(input string req, input logic [31:0] qa, input logic exp);
        cyc(1'b0, '0, 1'b0, 1'b1, qa, 1'b0);
        check({req, " valid"}, taint_vld, 1'b1);
        check(req, taint, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R1 reset valid", taint_vld, 1'b0);
        check("R1 reset taint", taint, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle valid", taint_vld, 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 1'b0) begin
                cyc(1'b1, VECS[i].addr, VECS[i].tag, 1'b0, '0, 1'b0);
            end else begin
                query($sformatf("R5 vector %0d", i), VECS[i].addr, VECS[i].exp);
            end
        end

        // R6: no query -> valid low, taint holds last value (1 from last vector)
        cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
        check("R6 idle valid", taint_vld, 1'b0);
        check("R6 hold", taint, 1'b1);
        query("R6 clean query", 32'h0000_0004, 1'b0);
        cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
        check("R6 hold clean", taint, 1'b0);

        // R3 far address spilled clean: hashes 75/85, no tagged overlap
        cyc(1'b1, 32'hDEAD_BEE0, 1'b0, 1'b0, '0, 1'b0);
        query("R3 far address", 32'hDEAD_BEE2, 1'b0);

        // R8: tagged spill and query of unseen k=9 in the same cycle
        cyc(1'b1, 32'h0000_0024, 1'b1, 1'b1, 32'h0000_0024, 1'b0);
        check("R8 spill+query tagged", taint, 1'b1);
        query("R8 after tagged spill", 32'h0000_0024, 1'b1);

        // R8: clean spill and query of unseen k=10 in the same cycle
        cyc(1'b1, 32'h0000_0028, 1'b0, 1'b1, 32'h0000_0028, 1'b0);
        check("R8 spill+query clean old state", taint, 1'b1);
        query("R8 after clean spill", 32'h0000_0028, 1'b0);

        // R8/R7: clear and query of clean k=1 in the same cycle
        cyc(1'b0, '0, 1'b0, 1'b1, 32'h0000_0004, 1'b1);
        check("R8 clear+query old state", taint, 1'b0);
        query("R7 after clear", 32'h0000_0004, 1'b1);
        query("R7 after clear k=10", 32'h0000_0028, 1'b1);

        // R7: spill in the same cycle as clear is discarded
        cyc(1'b1, 32'h0000_0004, 1'b0, 1'b0, '0, 1'b1);
        query("R7 spill dropped by clear", 32'h0000_0004, 1'b1);
        cyc(1'b1, 32'h0000_0004, 1'b0, 1'b0, '0, 1'b0);
        query("R7 spill after clear", 32'h0000_0004, 1'b0);

        // R1: reset mid-run empties filters
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again taint", taint, 1'b1);
        check("R1 reset again valid", taint_vld, 1'b0);
        rst = 1'b0;
        query("R1 after reset", 32'h0000_0004, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule